// File: doc/BRIEF.md
# Remote DMA Byte-Port Engine

This block lets a host reach local packet memory through one data port. The host loads a 16-bit remote address and a 16-bit transfer count, one byte at a time. Each port read or port write then touches memory at the current address. After the access the address moves forward and the count moves down by the access width. The access is 1 byte by default, 2 bytes in word mode, and 4 bytes when the long strobe is given. When the address reaches the end of the receive ring it returns to the start of the ring. When the count runs out, a sticky completion flag is raised.

Only two memory areas can be reached: a small identification area at the bottom of the space, and a packet window. A write outside these areas never reaches memory. A read outside them returns all ones. Multi-byte lanes are little-endian, and wide accesses always use an even memory address. Register decoding and the network side stay outside this block.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, the current address, the count, the completion flag and the read data are all zero.
- R2: `addr_lo_we_i` and `addr_hi_we_i` load bits 7:0 and 15:8 of the address from `reg_wdata_i`. `cnt_lo_we_i` and `cnt_hi_we_i` load the same bits of the count. Each strobe leaves the other byte unchanged. A port access in the same cycle as any load strobe is dropped.
- R3: The access width is set per access. It is 4 bytes when `acc_long_i` is 1. Otherwise it is 2 bytes when `word_mode_i` is 1, and 1 byte when both are 0. The address and the count each step by the access width.
- R4: After a step, if the address equals `stop_pg_i`*256, it is replaced by `start_pg_i`*256.
- R5: If the count is less than or equal to the step, the access sets the count to 0 and raises `done_o`. Otherwise the access subtracts the step from the count.
- R6: A port write while the count is 0 asserts no memory write and leaves the address and the count unchanged. A port read while the count is 0 still steps the address.
- R7: Word and long accesses drive the memory address with bit 0 cleared. The stored address keeps its raw value and steps from it. Byte k of the data (bits 8k+7:8k) maps to memory address+k.
- R8: An access is valid only when the memory address is below 32, or is at least 0x4000 and below 0xC000. An invalid write asserts no `mem_we_o`. An invalid read returns 0xFF, 0xFFFF or 0xFFFFFFFF according to the access width.
- R9: A `cmd_go_i` pulse while the count is 0 raises `done_o` on the next cycle. While the count is nonzero, the pulse has no effect.
- R10: `done_o` stays high until a `done_clr_i` pulse. When a set and a clear fall in the same cycle, the set wins.
- R11: Read data appears on `port_rdata_o` in the cycle after the read strobe. It is zero-extended above the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | 1 selects 2-byte accesses |
| acc_long_i | input | 1 | Marks the current access as 4 bytes |
| start_pg_i | input | 8 | First page of the ring |
| stop_pg_i | input | 8 | Page just past the end of the ring |
| reg_wdata_i | input | 8 | Byte for the address and count loads |
| addr_lo_we_i | input | 1 | Load the address low byte |
| addr_hi_we_i | input | 1 | Load the address high byte |
| cnt_lo_we_i | input | 1 | Load the count low byte |
| cnt_hi_we_i | input | 1 | Load the count high byte |
| cmd_go_i | input | 1 | Remote read or write command issued |
| done_clr_i | input | 1 | Clear pulse for the completion flag |
| port_rd_i | input | 1 | Port read strobe |
| port_wr_i | input | 1 | Port write strobe |
| port_wdata_i | input | 32 | Port write data |
| port_rdata_o | output | 32 | Port read data, registered |
| mem_addr_o | output | 16 | Memory byte address |
| mem_re_o | output | 1 | Memory read enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | 4 | Byte lanes of the access |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data; byte k is the byte at address+k |
| cur_addr_o | output | 16 | Current remote address |
| cur_cnt_o | output | 16 | Remaining count |
| done_o | output | 1 | Sticky completion flag |

## Verification
The bench uses the default parameters: an identification area of 32 bytes and a packet window from 0x4000 to 0xC000. A ring is set up from page 0x41 to page 0x43, so a mixed run of byte, word and long accesses crosses the wrap point. Other accesses are placed on both edges of the packet window and in the gap above the identification area. With these values the bench can reach the wrap, count exhaustion on an oversized step, and all-ones reads at each width.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_LONG = 2'd2
  } acc_e;

  function automatic logic [2:0] acc_step(acc_e a);
    case (a)
      ACC_WORD: return 3'd2;
      ACC_LONG: return 3'd4;
      default:  return 3'd1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] acc_mask(acc_e a);
    case (a)
      ACC_WORD: return LANES'(4'b0011);
      ACC_LONG: return LANES'(4'b1111);
      default:  return LANES'(4'b0001);
    endcase
  endfunction
endpackage

// File: rtl/rdma_win_dec.sv
module rdma_win_dec
  import rdma_pkg::*;
#(
  parameter int unsigned PROM_TOP = 32,
  parameter int unsigned PMEM_LO  = 16384,
  parameter int unsigned PMEM_HI  = 49152
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o
);
  logic [31:0] a32;
  assign a32     = 32'(addr_i);
  assign valid_o = (a32 < PROM_TOP) || ((a32 >= PMEM_LO) && (a32 < PMEM_HI));
endmodule

// File: rtl/rdma_lane.sv
module rdma_lane
  import rdma_pkg::*;
(
  input  acc_e              acc_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] port_wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  assign be_o = acc_mask(acc_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mem_wdata_o[8*k +: 8] = be_o[k] ? port_wdata_i[8*k +: 8] : 8'h00;
    // invalid window reads float high across the active lanes only
    assign rdata_o[8*k +: 8] = !be_o[k] ? 8'h00 :
                               (valid_i ? mem_rdata_i[8*k +: 8] : 8'hFF);
  end
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr
  import rdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              addr_lo_we_i,
  input  logic              addr_hi_we_i,
  input  logic              cnt_lo_we_i,
  input  logic              cnt_hi_we_i,
  input  logic              step_en_i,
  input  logic [2:0]        step_i,
  input  logic [PAGE_W-1:0] start_pg_i,
  input  logic [PAGE_W-1:0] stop_pg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              term_o
);
  logic [ADDR_W-1:0] addr_q, addr_inc, addr_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;

  assign addr_inc = addr_q + ADDR_W'(step_i);
  assign addr_nxt = (addr_inc == {stop_pg_i, 8'h00}) ? {start_pg_i, 8'h00} : addr_inc;
  assign term_o   = step_en_i && (cnt_q <= CNT_W'(step_i));
  assign cnt_nxt  = term_o ? '0 : cnt_q - CNT_W'(step_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_lo_we_i) addr_q[7:0]        <= byte_i;
      if (addr_hi_we_i) addr_q[ADDR_W-1:8] <= byte_i;
      if (cnt_lo_we_i)  cnt_q[7:0]         <= byte_i;
      if (cnt_hi_we_i)  cnt_q[CNT_W-1:8]   <= byte_i;
      if (step_en_i) begin
        addr_q <= addr_nxt;
        cnt_q  <= cnt_nxt;
      end
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int unsigned PROM_TOP = 32,
  parameter int unsigned PMEM_LO  = 16384,
  parameter int unsigned PMEM_HI  = 49152
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_mode_i,
  input  logic              acc_long_i,
  input  logic [7:0]        start_pg_i,
  input  logic [7:0]        stop_pg_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              addr_lo_we_i,
  input  logic              addr_hi_we_i,
  input  logic              cnt_lo_we_i,
  input  logic              cnt_hi_we_i,
  input  logic              cmd_go_i,
  input  logic              done_clr_i,
  input  logic              port_rd_i,
  input  logic              port_wr_i,
  input  logic [31:0]       port_wdata_i,
  output logic [31:0]       port_rdata_o,
  output logic [15:0]       mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic [15:0]       cur_addr_o,
  output logic [15:0]       cur_cnt_o,
  output logic              done_o
);
  acc_e              acc;
  logic              any_ld, cnt_zero, acc_rd, acc_wr, step_en, term, valid;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] lane_rdata;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q, done_set;

  assign acc      = acc_long_i ? ACC_LONG : (word_mode_i ? ACC_WORD : ACC_BYTE);
  assign any_ld   = addr_lo_we_i | addr_hi_we_i | cnt_lo_we_i | cnt_hi_we_i;
  assign cnt_zero = (cnt == '0);
  assign acc_rd   = port_rd_i & ~any_ld;
  assign acc_wr   = port_wr_i & ~any_ld & ~cnt_zero;
  assign step_en  = acc_rd | acc_wr;

  rdma_ptr u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_i       (reg_wdata_i),
    .addr_lo_we_i (addr_lo_we_i),
    .addr_hi_we_i (addr_hi_we_i),
    .cnt_lo_we_i  (cnt_lo_we_i),
    .cnt_hi_we_i  (cnt_hi_we_i),
    .step_en_i    (step_en),
    .step_i       (acc_step(acc)),
    .start_pg_i   (start_pg_i),
    .stop_pg_i    (stop_pg_i),
    .addr_o       (addr),
    .cnt_o        (cnt),
    .term_o       (term)
  );

  // wide accesses land on an even byte; the stored address keeps its raw value
  assign mem_addr_o = (acc == ACC_BYTE) ? addr : {addr[ADDR_W-1:1], 1'b0};

  rdma_win_dec #(
    .PROM_TOP (PROM_TOP),
    .PMEM_LO  (PMEM_LO),
    .PMEM_HI  (PMEM_HI)
  ) u_win (
    .addr_i  (mem_addr_o),
    .valid_o (valid)
  );

  rdma_lane u_lane (
    .acc_i        (acc),
    .valid_i      (valid),
    .port_wdata_i (port_wdata_i),
    .mem_rdata_i  (mem_rdata_i),
    .be_o         (mem_be_o),
    .mem_wdata_o  (mem_wdata_o),
    .rdata_o      (lane_rdata)
  );

  assign mem_re_o = acc_rd & valid;
  assign mem_we_o = acc_wr & valid;

  assign done_set = term | (cmd_go_i & cnt_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (acc_rd) rdata_q <= lane_rdata;
      done_q <= done_set | (done_q & ~done_clr_i);
    end
  end

  assign port_rdata_o = rdata_q;
  assign cur_addr_o   = addr;
  assign cur_cnt_o    = cnt;
  assign done_o       = done_q;
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk #(
  parameter int unsigned PROM_TOP = 32,
  parameter int unsigned PMEM_LO  = 16384,
  parameter int unsigned PMEM_HI  = 49152
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_mode_i,
  input logic        acc_long_i,
  input logic        addr_lo_we_i,
  input logic        addr_hi_we_i,
  input logic        cnt_lo_we_i,
  input logic        cnt_hi_we_i,
  input logic        cmd_go_i,
  input logic        done_clr_i,
  input logic        port_rd_i,
  input logic        port_wr_i,
  input logic [15:0] mem_addr_o,
  input logic        mem_re_o,
  input logic        mem_we_o,
  input logic [15:0] cur_addr_o,
  input logic [15:0] cur_cnt_o,
  input logic        done_o
);
  logic any_ld, mem_act;
  assign any_ld  = addr_lo_we_i | addr_hi_we_i | cnt_lo_we_i | cnt_hi_we_i;
  assign mem_act = mem_re_o | mem_we_o;

  assert_wr_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr_i && !any_ld && cur_cnt_o == 16'd0) |-> !mem_we_o);

  assert_wr_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr_i && !port_rd_i && !any_ld && cur_cnt_o == 16'd0)
      |=> ($stable(cur_cnt_o) && $stable(cur_addr_o)));

  assert_even_wide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_act && (acc_long_i || word_mode_i)) |-> !mem_addr_o[0]);

  assert_in_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_act |-> ((32'(mem_addr_o) < PROM_TOP) ||
                 (32'(mem_addr_o) >= PMEM_LO && 32'(mem_addr_o) < PMEM_HI)));

  assert_cnt_falls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((port_rd_i || port_wr_i) && !any_ld && cur_cnt_o != 16'd0)
      |=> (cur_cnt_o < $past(cur_cnt_o)));

  assert_go_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go_i && cur_cnt_o == 16'd0) |=> done_o);

  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_clr_i) |=> done_o);
endmodule

bind rdma_port_engine rdma_port_engine_chk #(
  .PROM_TOP (PROM_TOP),
  .PMEM_LO  (PMEM_LO),
  .PMEM_HI  (PMEM_HI)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_mode_i  (word_mode_i),
  .acc_long_i   (acc_long_i),
  .addr_lo_we_i (addr_lo_we_i),
  .addr_hi_we_i (addr_hi_we_i),
  .cnt_lo_we_i  (cnt_lo_we_i),
  .cnt_hi_we_i  (cnt_hi_we_i),
  .cmd_go_i     (cmd_go_i),
  .done_clr_i   (done_clr_i),
  .port_rd_i    (port_rd_i),
  .port_wr_i    (port_wr_i),
  .mem_addr_o   (mem_addr_o),
  .mem_re_o     (mem_re_o),
  .mem_we_o     (mem_we_o),
  .cur_addr_o   (cur_addr_o),
  .cur_cnt_o    (cur_cnt_o),
  .done_o       (done_o)
);

// File: tb/tb_rdma_port_engine.sv
`timescale 1ns/1ps
module tb_rdma_port_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0, acc_long = 1'b0;
  logic [7:0]  start_pg = 8'h41, stop_pg = 8'h43, reg_wdata = 8'h00;
  logic        alo = 1'b0, ahi = 1'b0, clo = 1'b0, chi = 1'b0;
  logic        go = 1'b0, clr = 1'b0, prd = 1'b0, pwr = 1'b0;
  logic [31:0] pwdata = '0, prdata, mwdata, mrdata;
  logic [15:0] maddr, caddr, ccnt;
  logic        mre, mwe, done;
  logic [3:0]  mbe;

  always #2 clk = ~clk;

  rdma_port_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .word_mode_i(word_mode), .acc_long_i(acc_long),
    .start_pg_i(start_pg), .stop_pg_i(stop_pg), .reg_wdata_i(reg_wdata),
    .addr_lo_we_i(alo), .addr_hi_we_i(ahi), .cnt_lo_we_i(clo), .cnt_hi_we_i(chi),
    .cmd_go_i(go), .done_clr_i(clr), .port_rd_i(prd), .port_wr_i(pwr),
    .port_wdata_i(pwdata), .port_rdata_o(prdata), .mem_addr_o(maddr),
    .mem_re_o(mre), .mem_we_o(mwe), .mem_be_o(mbe), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .cur_addr_o(caddr), .cur_cnt_o(ccnt), .done_o(done)
  );

  // bench memory, 1 KB aliased on the low address bits
  logic [7:0] bmem [1024];
  initial for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
  always_comb
    for (int k = 0; k < 4; k++) mrdata[8*k +: 8] = bmem[10'(maddr + 16'(k))];
  always @(posedge clk)
    if (mwe)
      for (int k = 0; k < 4; k++)
        if (mbe[k]) bmem[10'(maddr + 16'(k))] <= mwdata[8*k +: 8];

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  typedef enum logic [2:0] {OP_LA, OP_LC, OP_CLR, OP_WR, OP_RD} op_e;
  typedef struct packed {
    op_e         op;
    logic [1:0]  acc;   // 0 byte, 1 word, 2 long
    logic [31:0] data;
    logic [15:0] eaddr;
    logic [15:0] ecnt;
    logic        edone;
    logic        ewe;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{OP_LA,  2'd0, 32'h42FC,     16'h42FC, 16'h0000, 1'b0, 1'b0, 32'h0},
    '{OP_LC,  2'd0, 32'h0009,     16'h42FC, 16'h0009, 1'b0, 1'b0, 32'h0},
    '{OP_WR,  2'd0, 32'h11,       16'h42FD, 16'h0008, 1'b0, 1'b1, 32'h0},
    '{OP_WR,  2'd0, 32'h22,       16'h42FE, 16'h0007, 1'b0, 1'b1, 32'h0},
    '{OP_WR,  2'd1, 32'h4433,     16'h4100, 16'h0005, 1'b0, 1'b1, 32'h0},
    '{OP_WR,  2'd2, 32'h88776655, 16'h4104, 16'h0001, 1'b0, 1'b1, 32'h0},
    '{OP_WR,  2'd1, 32'hAA99,     16'h4106, 16'h0000, 1'b1, 1'b1, 32'h0},
    '{OP_WR,  2'd0, 32'hEE,       16'h4106, 16'h0000, 1'b1, 1'b0, 32'h0},
    '{OP_LA,  2'd0, 32'h42FC,     16'h42FC, 16'h0000, 1'b1, 1'b0, 32'h0},
    '{OP_LC,  2'd0, 32'h0010,     16'h42FC, 16'h0010, 1'b1, 1'b0, 32'h0},
    '{OP_CLR, 2'd0, 32'h0,        16'h42FC, 16'h0010, 1'b0, 1'b0, 32'h0},
    '{OP_RD,  2'd0, 32'h0,        16'h42FD, 16'h000F, 1'b0, 1'b0, 32'h11},
    '{OP_RD,  2'd1, 32'h0,        16'h42FF, 16'h000D, 1'b0, 1'b0, 32'h2211},
    '{OP_RD,  2'd0, 32'h0,        16'h4100, 16'h000C, 1'b0, 1'b0, 32'h44},
    '{OP_RD,  2'd2, 32'h0,        16'h4104, 16'h0008, 1'b0, 1'b0, 32'h88776655},
    '{OP_RD,  2'd1, 32'h0,        16'h4106, 16'h0006, 1'b0, 1'b0, 32'hAA99},
    '{OP_LA,  2'd0, 32'h0004,     16'h0004, 16'h0006, 1'b0, 1'b0, 32'h0},
    '{OP_WR,  2'd0, 32'h5A,       16'h0005, 16'h0005, 1'b0, 1'b1, 32'h0},
    '{OP_LA,  2'd0, 32'h0004,     16'h0004, 16'h0005, 1'b0, 1'b0, 32'h0},
    '{OP_RD,  2'd0, 32'h0,        16'h0005, 16'h0004, 1'b0, 1'b0, 32'h5A},
    '{OP_LA,  2'd0, 32'h0041,     16'h0041, 16'h0004, 1'b0, 1'b0, 32'h0},
    '{OP_WR,  2'd1, 32'h1234,     16'h0043, 16'h0002, 1'b0, 1'b0, 32'h0},
    '{OP_LA,  2'd0, 32'h0041,     16'h0041, 16'h0002, 1'b0, 1'b0, 32'h0},
    '{OP_RD,  2'd1, 32'h0,        16'h0043, 16'h0000, 1'b1, 1'b0, 32'hFFFF},
    '{OP_LA,  2'd0, 32'hBFFC,     16'hBFFC, 16'h0000, 1'b1, 1'b0, 32'h0},
    '{OP_LC,  2'd0, 32'h0100,     16'hBFFC, 16'h0100, 1'b1, 1'b0, 32'h0},
    '{OP_CLR, 2'd0, 32'h0,        16'hBFFC, 16'h0100, 1'b0, 1'b0, 32'h0},
    '{OP_RD,  2'd2, 32'h0,        16'hC000, 16'h00FC, 1'b0, 1'b0, 32'h0},
    '{OP_RD,  2'd2, 32'h0,        16'hC004, 16'h00F8, 1'b0, 1'b0, 32'hFFFFFFFF},
    '{OP_LA,  2'd0, 32'h3FFF,     16'h3FFF, 16'h00F8, 1'b0, 1'b0, 32'h0},
    '{OP_RD,  2'd0, 32'h0,        16'h4000, 16'h00F7, 1'b0, 1'b0, 32'hFF},
    '{OP_RD,  2'd0, 32'h0,        16'h4001, 16'h00F6, 1'b0, 1'b0, 32'h00}
  };

  task automatic ld_byte(input logic [7:0] b, input int which);
    @(negedge clk);
    reg_wdata = b;
    alo = (which == 0); ahi = (which == 1); clo = (which == 2); chi = (which == 3);
    @(negedge clk);
    alo = 1'b0; ahi = 1'b0; clo = 1'b0; chi = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [1:0] acc, input logic [31:0] d,
                        output bit we_seen);
    @(negedge clk);
    word_mode = (acc == 2'd1); acc_long = (acc == 2'd2);
    pwdata = d; pwr = wr; prd = !wr;
    #1 we_seen = mwe;
    @(negedge clk);
    pwr = 1'b0; prd = 1'b0; acc_long = 1'b0;
  endtask

  initial begin
    bit we_seen;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 addr", 32'(caddr), 0);
    chk("R1 cnt", 32'(ccnt), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 rdata", prdata, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.op)
        OP_LA: begin ld_byte(v.data[7:0], 0); ld_byte(v.data[15:8], 1); end
        OP_LC: begin ld_byte(v.data[7:0], 2); ld_byte(v.data[15:8], 3); end
        OP_CLR: begin
          @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        end
        OP_WR: begin
          access(1'b1, v.acc, v.data, we_seen);
          chk("R6 R8 mem write strobe", 32'(we_seen), 32'(v.ewe));
        end
        default: begin
          access(1'b0, v.acc, v.data, we_seen);
          chk("R7 R8 R11 read data", prdata, v.erd);
        end
      endcase
      chk("R3 R4 R7 address", 32'(caddr), 32'(v.eaddr));
      chk("R5 count", 32'(ccnt), 32'(v.ecnt));
      chk("R5 R10 done", 32'(done), 32'(v.edone));
    end

    // R7 memory contents, little-endian lanes
    chk("R7 byte 42FE", 32'(bmem[10'h2FE]), 32'h33);
    chk("R7 byte 4103", 32'(bmem[10'h103]), 32'h88);
    chk("R8 dropped write", 32'(bmem[10'h040]), 32'h00);

    // R2 separate byte loads
    ld_byte(8'h12, 0);
    chk("R2 addr lo only", 32'(caddr), 32'h4012);
    ld_byte(8'h7E, 1);
    chk("R2 addr hi only", 32'(caddr), 32'h7E12);
    ld_byte(8'h00, 2); ld_byte(8'h00, 3);
    chk("R2 cnt cleared", 32'(ccnt), 0);

    // R9 command with empty count, done is low at this point
    chk("R9 done before", 32'(done), 0);
    @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
    chk("R9 go on empty", 32'(done), 1);
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R10 cleared", 32'(done), 0);
    ld_byte(8'h03, 2);
    @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
    chk("R9 go nonzero", 32'(done), 0);

    // R10 set and clear together: set wins (cnt 3, long step)
    @(negedge clk); acc_long = 1'b1; prd = 1'b1; clr = 1'b1;
    @(negedge clk); acc_long = 1'b0; prd = 1'b0; clr = 1'b0;
    chk("R10 set beats clear", 32'(done), 1);
    chk("R5 oversize step", 32'(ccnt), 0);

    // R6 read with count zero still steps the address
    ld_byte(8'h40, 1); ld_byte(8'h20, 0);
    access(1'b0, 2'd1, 32'h0, we_seen);
    chk("R6 read at zero steps", 32'(caddr), 32'h4022);

    // R2 load beats a port access in the same cycle
    ld_byte(8'h04, 2);
    @(negedge clk); prd = 1'b1; alo = 1'b1; reg_wdata = 8'h50;
    @(negedge clk); prd = 1'b0; alo = 1'b0;
    chk("R2 load priority addr", 32'(caddr), 32'h4050);
    chk("R2 load priority cnt", 32'(ccnt), 32'h0004);

    fin = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule